// File: doc/BRIEF.md
# Register-mapped SPI master with byte FIFOs

The block is an SPI bus master controlled through a 32-bit word register file. Software pushes bytes into a 16-entry transmit queue. The shift engine sends each byte on MOSI and captures one byte from MISO at the same time. Every captured byte goes into a 16-entry receive queue. Software learns that a byte has finished by polling the receive-empty flag, and then reads the byte back.

A control word sets clock polarity, clock phase, bit order and an internal loopback. It also holds two enables and an inhibit bit that gate when shifting may start. The chip-select lines come from an active-low select register. A write of one key value to a reset register returns all state to its power-on values. Three interrupt-related words exist only as storage that software can read and write; they have no effect on the block.

The serial clock toggles once every `CLK_DIV` system clocks. A byte therefore takes 16 half-periods.

Top module: `spi_host_regs`

## Requirements
- R1: After reset the control word reads 0x180 (bit 8 inhibit and bit 7 manual select set). The select register reads all ones, so `cs_n` is all ones. Status reads 0x25, both occupancy words read 0, and `sclk` is low.
- R2: Byte offsets 0x1C, 0x20 and 0x28 hold plain 32-bit words. A write there reads back unchanged and has no effect on the rest of the block.
- R3: Shifting starts only when all of the following are true:
  - control bit 1 (enable) is 1;
  - control bit 2 (master) is 1;
  - control bit 8 (inhibit) is 0;
  - the transmit queue at 0x68 is not empty.
  With data queued and any of the first three conditions failing, `sclk` never toggles.
- R4: Each transmitted byte pushes exactly one received byte, read from bits 7:0 at 0x6C. When control bit 0 (loopback) is set, the received byte equals the transmitted byte. Status bit 0 goes high again once all received bytes have been read.
- R5: Control bit 3 (CPOL) sets the idle level of `sclk`. Control bit 4 (CPHA) selects the sampling edge: 0 samples on the leading edge of each bit, 1 on the trailing edge. Control bit 9 selects the bit order: 0 sends MSB first, 1 sends LSB first. The same order applies to both directions.
- R6: Bit n of the select word at 0x70 drives `cs_n[n]`, active low. When control bit 7 is 1, `cs_n` follows that register at all times and holds between bytes. When control bit 7 is 0, `cs_n` takes the register value only while a byte is shifting and is all ones otherwise.
- R7: Writing 0x0A to offset 0x40 restores every register and empties both queues. Any other value written there changes nothing.
- R8: Writing control bit 5 empties only the transmit queue. Writing control bit 6 empties only the receive queue. Both bits read back as 0 from the following cycle.
- R9: The transmit occupancy word at 0x74 holds the entry count, 0 to 16. A write to 0x68 while 16 entries are queued is dropped. Status bit 3 shows full and bit 2 shows empty.
- R10: The receive occupancy word at 0x78 holds the count, 0 to 16. A byte that finishes while 16 entries are held is dropped. Status bit 1 shows full. A read of 0x6C while the queue is empty returns 0.
- R11: Each half-period of `sclk` during a byte lasts exactly `CLK_DIV` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; pops the receive queue when it reads offset 0x6C |
| bus_addr | input | 7 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, valid in the same cycle |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The assertions check on every cycle that:
- neither queue count goes past its depth;
- shifting begins only under the enable and inhibit conditions;
- a queue-flush bit always empties its queue and clears itself;
- the keyed reset returns the control word and both counts to their reset values;
- in automatic select mode, `cs_n` is all ones whenever no byte is shifting.

Some behaviour only the directed scenarios can show. A slave model in the bench exercises all four clock modes and both bit orders, and checks that the bytes exchanged in each direction match. The scenarios also cover loopback data, dropped writes when the transmit queue is full, dropped bytes when the receive queue is full, and the half-period length.

// File: rtl/spi_host_regs.sv
module spi_host_regs #(
  parameter int CLK_DIV = 4,
  parameter int NUM_CS  = 4,
  parameter int DEPTH   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [6:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = AW + 1;
  localparam int DIVW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIVW-1:0] DIV_END  = DIVW'(CLK_DIV - 1);
  localparam logic [CW-1:0]   FULL_CNT = CW'(DEPTH);
  localparam logic [9:0]      CTRL_RST = 10'h180;

  localparam logic [6:0] A_GIE = 7'h1C, A_ISR = 7'h20, A_IER = 7'h28, A_SRR = 7'h40;
  localparam logic [6:0] A_CTL = 7'h60, A_STA = 7'h64, A_TXD = 7'h68, A_RXD = 7'h6C;
  localparam logic [6:0] A_SEL = 7'h70, A_TOC = 7'h74, A_ROC = 7'h78;

  logic [9:0]        ctrl;
  logic [NUM_CS-1:0] ssr;
  logic [31:0]       gie_q, isr_q, ier_q;

  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  logic            busy, sclk_q;
  logic [DIVW-1:0] div_cnt;
  logic [3:0]      edge_cnt;
  logic [2:0]      out_idx;
  logic [7:0]      byte_q, rx_sr;

  wire srst    = bus_wr && bus_addr == A_SRR && bus_wdata == 32'h0000_000A;
  wire wr_ctl  = bus_wr && bus_addr == A_CTL;
  wire tx_full = tx_cnt == FULL_CNT;
  wire rx_full = rx_cnt == FULL_CNT;
  wire tx_push = bus_wr && bus_addr == A_TXD && !tx_full && !ctrl[5];
  wire go      = !busy && ctrl[1] && ctrl[2] && !ctrl[8] && tx_cnt != '0;
  wire rx_pop  = bus_rd && bus_addr == A_RXD && rx_cnt != '0;

  wire tick  = busy && div_cnt == DIV_END;
  wire lead  = !edge_cnt[0];
  wire samp  = tick && (lead ^ ctrl[4]);
  wire shift = tick && !samp && !(ctrl[4] ? edge_cnt == 4'd0 : edge_cnt == 4'd15);
  wire last  = tick && edge_cnt == 4'd15;

  wire       din     = ctrl[0] ? mosi : miso;
  wire [7:0] rx_next = ctrl[9] ? {din, rx_sr[7:1]} : {rx_sr[6:0], din};
  wire [7:0] rx_done = samp ? rx_next : rx_sr;
  wire       rx_push = last && !rx_full && !ctrl[6];

  assign mosi = ctrl[9] ? byte_q[out_idx] : byte_q[3'd7 - out_idx];
  assign sclk = busy ? sclk_q : ctrl[3];
  assign cs_n = (ctrl[7] || busy) ? ssr : '1;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_GIE: bus_rdata = gie_q;
      A_ISR: bus_rdata = isr_q;
      A_IER: bus_rdata = ier_q;
      A_CTL: bus_rdata = {22'd0, ctrl};
      A_STA: bus_rdata = {26'd0, 1'b1, 1'b0, tx_full, tx_cnt == '0, rx_full, rx_cnt == '0};
      A_RXD: bus_rdata = (rx_cnt != '0) ? {24'd0, rx_mem[rx_rp]} : '0;
      A_SEL: bus_rdata = {{(32-NUM_CS){1'b0}}, ssr};
      A_TOC: bus_rdata = {{(32-CW){1'b0}}, tx_cnt};
      A_ROC: bus_rdata = {{(32-CW){1'b0}}, rx_cnt};
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= CTRL_RST; ssr <= '1; gie_q <= '0; isr_q <= '0; ier_q <= '0;
    end else if (srst) begin
      ctrl <= CTRL_RST; ssr <= '1; gie_q <= '0; isr_q <= '0; ier_q <= '0;
    end else begin
      if (wr_ctl) ctrl <= bus_wdata[9:0];
      else        ctrl[6:5] <= 2'b00;
      if (bus_wr && bus_addr == A_SEL) ssr   <= bus_wdata[NUM_CS-1:0];
      if (bus_wr && bus_addr == A_GIE) gie_q <= bus_wdata;
      if (bus_wr && bus_addr == A_ISR) isr_q <= bus_wdata;
      if (bus_wr && bus_addr == A_IER) ier_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[7:0];
    if (rx_push) rx_mem[rx_wp] <= rx_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (srst || ctrl[5]) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (go)      tx_rp <= tx_rp + 1'b1;
      case ({tx_push, go})
        2'b10:   tx_cnt <= tx_cnt + 1'b1;
        2'b01:   tx_cnt <= tx_cnt - 1'b1;
        default: tx_cnt <= tx_cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (srst || ctrl[6]) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      case ({rx_push, rx_pop})
        2'b10:   rx_cnt <= rx_cnt + 1'b1;
        2'b01:   rx_cnt <= rx_cnt - 1'b1;
        default: rx_cnt <= rx_cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; sclk_q <= 1'b0; div_cnt <= '0; edge_cnt <= '0;
      out_idx <= '0; byte_q <= '0; rx_sr <= '0;
    end else if (srst || !ctrl[1]) begin
      busy <= 1'b0; div_cnt <= '0; edge_cnt <= '0; out_idx <= '0;
    end else if (go) begin
      busy     <= 1'b1;
      byte_q   <= tx_mem[tx_rp];
      sclk_q   <= ctrl[3];
      div_cnt  <= '0;
      edge_cnt <= '0;
      out_idx  <= '0;
      rx_sr    <= '0;
    end else if (busy) begin
      if (tick) begin
        div_cnt  <= '0;
        sclk_q   <= ~sclk_q;
        edge_cnt <= edge_cnt + 1'b1;
        if (samp)  rx_sr   <= rx_next;
        if (shift) out_idx <= out_idx + 1'b1;
        if (last)  busy    <= 1'b0;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_host_regs_chk.sv
module spi_host_regs_chk #(
  parameter int DEPTH  = 16,
  parameter int NUM_CS = 4,
  parameter int CW     = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [6:0]        bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [9:0]        ctrl,
  input logic              busy,
  input logic [CW-1:0]     tx_cnt,
  input logic [CW-1:0]     rx_cnt,
  input logic [NUM_CS-1:0] cs_n
);
  p_tx_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH));

  p_rx_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH));

  p_start_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ctrl[1] && ctrl[2] && !ctrl[8]));

  p_tx_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[5] |=> tx_cnt == '0);

  p_rx_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[6] |=> rx_cnt == '0);

  p_flush_self_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[6:5] != 2'b00) && !(bus_wr && bus_addr == 7'h60) |=> ctrl[6:5] == 2'b00);

  p_key_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 7'h40 && bus_wdata == 32'h0000_000A
      |=> ctrl == 10'h180 && tx_cnt == '0 && rx_cnt == '0);

  p_auto_cs_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[7] && !busy |-> cs_n == '1);
endmodule

bind spi_host_regs spi_host_regs_chk #(.DEPTH(DEPTH), .NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .ctrl(ctrl), .busy(busy), .tx_cnt(tx_cnt),
  .rx_cnt(rx_cnt), .cs_n(cs_n)
);

// File: tb/test_spi_host_regs.sv
module test_spi_host_regs;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV = 4;
  localparam int NUM_CS = 4;
  localparam int DEPTH = 16;

  localparam logic [6:0] A_GIE = 7'h1C, A_ISR = 7'h20, A_IER = 7'h28, A_SRR = 7'h40;
  localparam logic [6:0] A_CTL = 7'h60, A_STA = 7'h64, A_TXD = 7'h68, A_RXD = 7'h6C;
  localparam logic [6:0] A_SEL = 7'h70, A_TOC = 7'h74, A_ROC = 7'h78;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [6:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic sclk, mosi;
  logic miso = 1'b0;
  logic [NUM_CS-1:0] cs_n;

  int vectors = 0, miscompares = 0;

  spi_host_regs #(.CLK_DIV(CLK_DIV), .NUM_CS(NUM_CS), .DEPTH(DEPTH)) i_spi_host_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic sl_en = 1'b0, sl_cpol = 1'b0, sl_cpha = 1'b0, sl_lsb = 1'b0;
  logic [7:0] sl_tx = '0, sl_rx = '0;
  int sl_idx = 0;
  int toggles = 0;
  longint edge_t = 0, edge_prev = 0;

  function automatic logic sl_bit(logic [7:0] b, int i, logic lsb);
    return lsb ? b[i] : b[7-i];
  endfunction

  always @(sclk) begin
    toggles++;
    edge_prev = edge_t;
    edge_t = $time;
    #1;
    if (sl_en) begin
      if ((sclk != sl_cpol) == !sl_cpha)
        sl_rx = sl_lsb ? {mosi, sl_rx[7:1]} : {sl_rx[6:0], mosi};
      else if (!sl_cpha) begin
        sl_idx++;
        if (sl_idx < 8) miso = sl_bit(sl_tx, sl_idx, sl_lsb);
      end else begin
        if (sl_idx < 8) miso = sl_bit(sl_tx, sl_idx, sl_lsb);
        sl_idx++;
      end
    end
  end

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic expect_reg(string req, logic [6:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic wait_rx(int n);
    logic [31:0] v;
    for (int k = 0; k < 600; k++) begin
      rd(A_ROC, v);
      if (v == 32'(n)) break;
    end
  endtask

  task automatic t_reset;
    check("R1 cs_n", 32'(cs_n), 32'hF);
    check("R1 sclk", 32'(sclk), 32'h0);
    expect_reg("R1 ctrl", A_CTL, 32'h180);
    expect_reg("R1 select", A_SEL, 32'hF);
    expect_reg("R1 status", A_STA, 32'h25);
    expect_reg("R1 tx occ", A_TOC, 32'h0);
    expect_reg("R1 rx occ", A_ROC, 32'h0);
  endtask

  task automatic t_plain_regs;
    wr(A_SRR, 32'h0A);
    wr(A_GIE, 32'h8000_0000);
    wr(A_ISR, 32'hDEAD_0003);
    wr(A_IER, 32'h0000_001F);
    expect_reg("R2 gie", A_GIE, 32'h8000_0000);
    expect_reg("R2 isr", A_ISR, 32'hDEAD_0003);
    expect_reg("R2 ier", A_IER, 32'h0000_001F);
    expect_reg("R2 ctrl untouched", A_CTL, 32'h180);
  endtask

  task automatic t_gating;
    logic [31:0] v;
    wr(A_SRR, 32'h0A);
    wr(A_CTL, 32'h187);
    wr(A_TXD, 32'h5A);
    toggles = 0;
    repeat (60) @(negedge clk);
    check("R3 inhibit blocks", 32'(toggles), 32'h0);
    wr(A_CTL, 32'h085);
    repeat (60) @(negedge clk);
    check("R3 enable off blocks", 32'(toggles), 32'h0);
    wr(A_CTL, 32'h083);
    repeat (60) @(negedge clk);
    check("R3 master off blocks", 32'(toggles), 32'h0);
    expect_reg("R3 still queued", A_TOC, 32'h1);
    wr(A_CTL, 32'h087);
    wait_rx(1);
    check("R3 byte shifted", 32'(toggles), 32'd16);
    rd(A_RXD, v);
    check("R3 data", v, 32'h5A);
  endtask

  task automatic t_loopback;
    logic [31:0] v;
    logic [7:0] pat [3] = '{8'hA5, 8'h3C, 8'h00};
    wr(A_SRR, 32'h0A);
    wr(A_CTL, 32'h187);
    for (int i = 0; i < 3; i++) wr(A_TXD, {24'hFFFF_FF, pat[i]});
    wr(A_CTL, 32'h087);
    wait_rx(3);
    expect_reg("R4 one rx per tx", A_ROC, 32'h3);
    for (int i = 0; i < 3; i++) begin
      rd(A_RXD, v);
      check("R4 loopback byte", v, 32'(pat[i]));
    end
    expect_reg("R4 rx empty after reads", A_STA, 32'h25);
  endtask

  task automatic mode_xfer(logic cpol, logic cpha, logic lsb, logic [7:0] mb, logic [7:0] sb);
    logic [31:0] base, v;
    base = 32'h186 | (32'(cpol) << 3) | (32'(cpha) << 4) | (32'(lsb) << 9);
    wr(A_SRR, 32'h0A);
    wr(A_CTL, base);
    wr(A_TXD, 32'(mb));
    sl_cpol = cpol; sl_cpha = cpha; sl_lsb = lsb;
    sl_tx = sb; sl_rx = '0; sl_idx = 0;
    miso = sl_bit(sb, 0, lsb);
    sl_en = 1'b1;
    wr(A_CTL, base & ~32'h100);
    wait_rx(1);
    sl_en = 1'b0;
    rd(A_RXD, v);
    check("R5 master received", v, 32'(sb));
    check("R5 slave received", 32'(sl_rx), 32'(mb));
    check("R5 idle level", 32'(sclk), 32'(cpol));
  endtask

  task automatic t_modes;
    mode_xfer(1'b0, 1'b0, 1'b0, 8'hC6, 8'h5B);
    check("R11 half period", 32'(edge_t - edge_prev), 32'(CLK_DIV * CLK_PERIOD));
    mode_xfer(1'b0, 1'b1, 1'b0, 8'h81, 8'h7E);
    mode_xfer(1'b1, 1'b0, 1'b0, 8'h12, 8'hE4);
    mode_xfer(1'b1, 1'b1, 1'b0, 8'hF0, 8'h0D);
    mode_xfer(1'b0, 1'b0, 1'b1, 8'h01, 8'h80);
    mode_xfer(1'b1, 1'b1, 1'b1, 8'h9A, 8'h35);
  endtask

  task automatic t_select;
    wr(A_SRR, 32'h0A);
    wr(A_SEL, 32'hE);
    wr(A_CTL, 32'h187);
    check("R6 manual follows reg", 32'(cs_n), 32'hE);
    wr(A_TXD, 32'h11);
    wr(A_TXD, 32'h22);
    wr(A_CTL, 32'h087);
    wait_rx(2);
    check("R6 manual holds after bytes", 32'(cs_n), 32'hE);
    wr(A_SEL, 32'hB);
    check("R6 manual new value", 32'(cs_n), 32'hB);
    wr(A_CTL, 32'h107);
    check("R6 auto idle", 32'(cs_n), 32'hF);
    wr(A_TXD, 32'h33);
    wr(A_CTL, 32'h007);
    repeat (3) @(negedge clk);
    check("R6 auto during byte", 32'(cs_n), 32'hB);
    wait_rx(3);
    check("R6 auto after byte", 32'(cs_n), 32'hF);
  endtask

  task automatic t_soft_reset;
    wr(A_SRR, 32'h0A);
    wr(A_IER, 32'h55);
    wr(A_SEL, 32'h3);
    wr(A_CTL, 32'h187);
    wr(A_TXD, 32'h11);
    wr(A_SRR, 32'h05);
    expect_reg("R7 wrong key ier", A_IER, 32'h55);
    expect_reg("R7 wrong key ctrl", A_CTL, 32'h187);
    expect_reg("R7 wrong key tx occ", A_TOC, 32'h1);
    wr(A_SRR, 32'h0A);
    expect_reg("R7 key ctrl", A_CTL, 32'h180);
    expect_reg("R7 key ier", A_IER, 32'h0);
    expect_reg("R7 key select", A_SEL, 32'hF);
    expect_reg("R7 key tx occ", A_TOC, 32'h0);
    check("R7 key cs_n", 32'(cs_n), 32'hF);
  endtask

  task automatic t_flush;
    wr(A_SRR, 32'h0A);
    wr(A_CTL, 32'h187);
    for (int i = 0; i < 3; i++) wr(A_TXD, 32'(i));
    expect_reg("R8 queued", A_TOC, 32'h3);
    wr(A_CTL, 32'h1A7);
    expect_reg("R8 tx bit self clears", A_CTL, 32'h187);
    expect_reg("R8 tx flushed", A_TOC, 32'h0);
    wr(A_TXD, 32'h21);
    wr(A_TXD, 32'h22);
    wr(A_CTL, 32'h087);
    wait_rx(2);
    wr(A_CTL, 32'h187);
    wr(A_TXD, 32'h33);
    wr(A_CTL, 32'h1C7);
    expect_reg("R8 rx bit self clears", A_CTL, 32'h187);
    expect_reg("R8 rx flushed", A_ROC, 32'h0);
    expect_reg("R8 tx kept", A_TOC, 32'h1);
  endtask

  task automatic t_full;
    logic [31:0] v;
    wr(A_SRR, 32'h0A);
    wr(A_CTL, 32'h187);
    for (int i = 0; i < DEPTH; i++) wr(A_TXD, 32'(i + 8'h40));
    expect_reg("R9 tx full status", A_STA, 32'h29);
    expect_reg("R9 tx occ 16", A_TOC, 32'(DEPTH));
    wr(A_TXD, 32'hEE);
    expect_reg("R9 write when full dropped", A_TOC, 32'(DEPTH));
    wr(A_CTL, 32'h087);
    wait_rx(DEPTH);
    expect_reg("R10 rx full status", A_STA, 32'h26);
    wr(A_CTL, 32'h187);
    wr(A_TXD, 32'h77);
    wr(A_CTL, 32'h087);
    repeat (24 * CLK_DIV) @(negedge clk);
    expect_reg("R10 tx drained", A_TOC, 32'h0);
    expect_reg("R10 overflow byte dropped", A_ROC, 32'(DEPTH));
    for (int i = 0; i < DEPTH; i++) begin
      rd(A_RXD, v);
      check("R10 rx order", v, 32'(i + 8'h40));
    end
    expect_reg("R10 empty read returns 0", A_RXD, 32'h0);
    expect_reg("R10 empty status", A_STA, 32'h25);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_plain_regs;
    t_gating;
    t_loopback;
    t_modes;
    t_select;
    t_soft_reset;
    t_flush;
    t_full;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule